// File: doc/BRIEF.md
# Guard-Bit Constant Sum-of-Products Unit

This block computes a fixed-point sum of products `s = sum(c[k] * v[k])` over a fixed number of terms. Each `c[k]` is one entry of a small table of constant coefficients that is set at elaboration. Each entry has its own integer value and its own LSB position. The variables `v[k]` arrive one per cycle as signed two's-complement words. All variables share one known format.

A value with MSB position `m` and LSB position `l` means `-2^m*z_m + sum(2^i*z_i)` for `i` from `l` to `m-1`. The result format `(ms, ls)` is chosen beforehand from a guaranteed magnitude bound, so the sum can never exceed it.

Every product is shifted so that its LSB lines up with an accumulator LSB placed `g = ceil(log2 N)` bits below `ls`. The product is added at that precision. When the last term has been added, the `g` extra low bits are discarded by an arithmetic right shift. This keeps the error of the discarded bits below one result ulp.

A caller pulses `start`, presents exactly N terms as (variable, coefficient index) pairs, and then reads the result when `done` pulses.

Top module: `guard_sop_unit`

## Requirements
- R1: After reset, `done_o` is low and `result_o` is zero.
- R2: A cycle with `start_i` high clears the running sum and the term count and opens a new evaluation. A term presented in that same cycle is dropped.
- R3: The coefficient table defaults to four entries.
  - Entry 0: value 90, LSB -6.
  - Entry 1: value -77, LSB -7.
  - Entry 2: value 127, LSB -5.
  - Entry 3: value -128, LSB -8.

  The variable format has LSB -6. The accumulator LSB is `ls - g = -12`, so the alignment shift `coefLSB + varLSB + 12` is 0, -1, +1 and -2 for entries 0 to 3. Each accepted term adds `v * c` after that shift: a left shift for positive amounts, and a floor (arithmetic right shift) for negative amounts.
- R4: The result in format (6, -10) is 17 bits wide. It equals the floor of the 19-bit accumulator divided by `2^g = 4`. Negative sums are sign-correct.
- R5: When every term uses entries 0 or 2, no product bits are lost. The error then stays below one ulp: `result*2^-10 <= exact < result*2^-10 + 2^-10`.
- R6: `done_o` is high for exactly one cycle. That cycle is the one right after the cycle in which the N-th term (N = 4) was presented. `result_o` holds its value until the next start.
- R7: A term presented while no evaluation is open changes neither `result_o` nor `done_o`.
- R8: A start issued part-way through an evaluation discards the terms already taken. Only the N terms after it count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new evaluation and clears the sum |
| term_valid_i | input | 1 | A term is present this cycle |
| term_var_i | input | 8 | Signed variable word (LSB -6) |
| term_idx_i | input | 2 | Coefficient table index |
| result_o | output | 17 | Signed sum in format (6, -10) |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Every accepted term updates the registered sum at the edge that takes it. The result is a combinational shift of that register, so a value is visible in the half cycle after the edge. Inputs change on falling edges, and each term's effect is sampled on the next falling edge. `done_o` must be low at the falling edges after terms 1 to 3, high at the one after term 4, and low again one cycle later, while `result_o` stays the same. Checks for ignored terms and restarts sample the result one full cycle after the stimulus, before anything else is driven.

// File: rtl/gsop_pkg.sv
package gsop_pkg;

  // Number of extra fractional bits needed to keep N truncations under one ulp.
  function automatic int guard_bits(input int n_terms);
    return (n_terms <= 1) ? 0 : $clog2(n_terms);
  endfunction

  // Left-shift amount (negative = right shift) from a product LSB to the accumulator LSB.
  function automatic int align_shift(input int coef_lsb, input int var_lsb,
                                     input int res_lsb, input int guard);
    return coef_lsb + var_lsb - (res_lsb - guard);
  endfunction

endpackage

// File: rtl/gsop_coef_table.sv
module gsop_coef_table
  import gsop_pkg::*;
#(
  parameter int N_COEF = 4,
  parameter int COEF_W = 8,
  parameter int IDX_W = 2,
  parameter int SH_W = 8,
  parameter logic [N_COEF*COEF_W-1:0] COEF_VALS = '0,
  parameter logic [N_COEF*8-1:0] COEF_LSBS = '0,
  parameter int VAR_LSB = 0,
  parameter int RES_LSB = 0,
  parameter int GUARD = 0
) (
  input  logic [IDX_W-1:0]         idx_i,
  output logic signed [COEF_W-1:0] coef_o,
  output logic signed [SH_W-1:0]   shift_o
);

  logic signed [COEF_W-1:0] coef_tab [N_COEF];
  logic signed [SH_W-1:0]   shift_tab [N_COEF];

  for (genvar e = 0; e < N_COEF; e++) begin : g_entry
    localparam logic signed [7:0] ENTRY_LSB = COEF_LSBS[e*8 +: 8];
    localparam int ENTRY_SH = align_shift(int'(ENTRY_LSB), VAR_LSB, RES_LSB, GUARD);
    assign coef_tab[e]  = COEF_VALS[e*COEF_W +: COEF_W];
    assign shift_tab[e] = SH_W'(ENTRY_SH);
  end

  always_comb begin
    coef_o  = '0;
    shift_o = '0;
    for (int e = 0; e < N_COEF; e++) begin
      if (int'(idx_i) == e) begin
        coef_o  = coef_tab[e];
        shift_o = shift_tab[e];
      end
    end
  end

endmodule

// File: rtl/gsop_term_align.sv
module gsop_term_align #(
  parameter int VAR_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W = 19,
  parameter int SH_W = 8
) (
  input  logic signed [VAR_W-1:0]  var_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [SH_W-1:0]   shift_i,
  output logic signed [ACC_W-1:0]  term_o
);

  localparam int PW    = VAR_W + COEF_W;
  localparam int EXT_W = ACC_W + PW;

  // Place a product on the accumulator grid; right shifts floor toward minus infinity.
  function automatic logic signed [ACC_W-1:0] place_on_grid(
      input logic signed [PW-1:0] p, input logic signed [SH_W-1:0] sh);
    logic signed [EXT_W-1:0] ext;
    ext = {{(EXT_W-PW){p[PW-1]}}, p};
    if (sh >= 0) ext = ext <<< sh;
    else         ext = ext >>> (-sh);
    return ext[ACC_W-1:0];
  endfunction

  logic signed [PW-1:0] product;
  assign product = var_i * coef_i;
  assign term_o  = place_on_grid(product, shift_i);

endmodule

// File: rtl/gsop_accum.sv
module gsop_accum #(
  parameter int N_TERMS = 4,
  parameter int ACC_W = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    term_valid_i,
  input  logic signed [ACC_W-1:0] addend_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic                    done_o
);

  localparam int CNT_W = $clog2(N_TERMS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             open_q;
  logic             done_q;
  logic signed [ACC_W-1:0] acc_q;

  // Named events for the assertions.
  logic take_term;
  logic take_last;
  assign take_term = open_q && term_valid_i && !start_i;
  assign take_last = take_term && (cnt_q == CNT_W'(N_TERMS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      open_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= take_last;
      if (start_i) begin
        acc_q  <= '0;
        cnt_q  <= '0;
        open_q <= 1'b1;
      end else if (take_term) begin
        acc_q <= acc_q + addend_i;
        cnt_q <= cnt_q + 1'b1;
        if (take_last) open_q <= 1'b0;
      end
    end
  end

  assign acc_o  = acc_q;
  assign done_o = done_q;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_last |=> (done_q && !open_q));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (acc_q == '0 && open_q && !done_q));

  assert_idle_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !start_i) |=> $stable(acc_q));

endmodule

// File: rtl/guard_sop_unit.sv
module guard_sop_unit
  import gsop_pkg::*;
#(
  parameter int N_TERMS = 4,
  parameter int N_COEF = 4,
  parameter int VAR_W = 8,
  parameter int VAR_LSB = -6,
  parameter int COEF_W = 8,
  parameter logic [N_COEF*COEF_W-1:0] COEF_VALS = {8'h80, 8'h7F, 8'hB3, 8'h5A},
  parameter logic [N_COEF*8-1:0] COEF_LSBS = {8'hF8, 8'hFB, 8'hF9, 8'hFA},
  parameter int RES_MSB = 6,
  parameter int RES_LSB = -10,
  parameter int IDX_W = (N_COEF <= 1) ? 1 : $clog2(N_COEF),
  parameter int RES_W = RES_MSB - RES_LSB + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             term_valid_i,
  input  logic [VAR_W-1:0] term_var_i,
  input  logic [IDX_W-1:0] term_idx_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);

  localparam int G     = guard_bits(N_TERMS);
  localparam int ACC_W = RES_W + G;
  localparam int SH_W  = 8;

  logic signed [COEF_W-1:0] coef;
  logic signed [SH_W-1:0]   shift;
  logic signed [ACC_W-1:0]  term_aligned;
  logic signed [ACC_W-1:0]  acc;

  gsop_coef_table #(
    .N_COEF(N_COEF), .COEF_W(COEF_W), .IDX_W(IDX_W), .SH_W(SH_W),
    .COEF_VALS(COEF_VALS), .COEF_LSBS(COEF_LSBS),
    .VAR_LSB(VAR_LSB), .RES_LSB(RES_LSB), .GUARD(G)
  ) u_table (
    .idx_i(term_idx_i), .coef_o(coef), .shift_o(shift)
  );

  gsop_term_align #(
    .VAR_W(VAR_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .SH_W(SH_W)
  ) u_align (
    .var_i(term_var_i), .coef_i(coef), .shift_i(shift), .term_o(term_aligned)
  );

  gsop_accum #(
    .N_TERMS(N_TERMS), .ACC_W(ACC_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .term_valid_i(term_valid_i),
    .addend_i(term_aligned), .acc_o(acc), .done_o(done_o)
  );

  // Discard the guard bits by a floor shift so negative sums stay sign-correct.
  function automatic logic [RES_W-1:0] drop_guard(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] s;
    s = a >>> G;
    return s[RES_W-1:0];
  endfunction

  assign result_o = drop_guard(acc);

  assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(result_o) || $past(start_i));

endmodule

// File: tb/guard_sop_unit_bench.sv
module guard_sop_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  tvar = '0;
  logic [1:0]  tidx = '0;
  logic [16:0] result;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;

  int cval [4] = '{90, -77, 127, -128};
  int clsb [4] = '{-6, -7, -5, -8};

  always #10 clk = ~clk;

  guard_sop_unit u_guard_sop_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .term_valid_i(valid),
    .term_var_i(tvar), .term_idx_i(tidx), .result_o(result), .done_o(done)
  );

  function automatic int floor_div(input int a, input int d);
    int q;
    q = a / d;
    if ((a % d) != 0 && a < 0) q = q - 1;
    return q;
  endfunction

  // Shift to the grid at 2^-12: product LSB is coefLSB - 6.
  function automatic int grid_shift(input int i);
    return (clsb[i] - 6) + 12;
  endfunction

  function automatic int expect_sum(input int ix [4], input int vv [4]);
    int total;
    total = 0;
    for (int k = 0; k < 4; k++) begin
      int p;
      int s;
      p = vv[k] * cval[ix[k]];
      s = grid_shift(ix[k]);
      if (s >= 0) total += p * (1 << s);
      else        total += floor_div(p, 1 << (-s));
    end
    return floor_div(total, 4);
  endfunction

  function automatic int res_int();
    return int'($signed(result));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_terms(input int ix [4], input int vv [4], output bit early);
    early = 1'b0;
    for (int k = 0; k < 4; k++) begin
      valid = 1'b1;
      tidx  = 2'(ix[k]);
      tvar  = 8'(vv[k]);
      @(negedge clk);
      if (k < 3 && done) early = 1'b1;
    end
    valid = 1'b0;
  endtask

  task automatic run_eval(input int ix [4], input int vv [4], input string req);
    bit early;
    int got;
    int exp;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    send_terms(ix, vv, early);
    got = res_int();
    exp = expect_sum(ix, vv);
    check(!early && done, "R6 done timing", int'(done), 1);
    check(got == exp, req, got, exp);
    @(negedge clk);
    check(!done && res_int() == got, "R6 hold", res_int(), got);
  endtask

  initial begin
    int ix [4];
    int vv [4];
    int held;
    bit early;

    repeat (3) @(negedge clk);
    check(!done && result == '0, "R1 reset state", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && result == '0, "R1 after release", int'(result), 0);

    // R3/R4: sweep every index combination with varied variables.
    for (int combo = 0; combo < 256; combo++) begin
      for (int k = 0; k < 4; k++) begin
        ix[k] = (combo >> (2 * k)) & 3;
        vv[k] = ((combo * 37 + k * 91 + 13) % 256) - 128;
      end
      run_eval(ix, vv, "R3 R4 sum");
    end

    // R4: extreme variables with a single repeated coefficient.
    for (int c = 0; c < 4; c++) begin
      for (int e = 0; e < 4; e++) begin
        for (int k = 0; k < 4; k++) begin
          ix[k] = c;
          vv[k] = (e == 0) ? -128 : (e == 1) ? 127 : (e == 2) ? -1 : ((k % 2) ? 127 : -128);
        end
        run_eval(ix, vv, "R4 extremes");
      end
    end

    // R5: lossless alignment keeps the error under one ulp.
    for (int combo = 0; combo < 16; combo++) begin
      int exact;
      int r;
      for (int k = 0; k < 4; k++) begin
        ix[k] = ((combo >> k) & 1) ? 2 : 0;
        vv[k] = ((combo * 53 + k * 29 + 7) % 256) - 128;
      end
      run_eval(ix, vv, "R5 sum");
      exact = 0;
      for (int k = 0; k < 4; k++) exact += vv[k] * cval[ix[k]] * (1 << (clsb[ix[k]] - 6 + 14));
      r = res_int() * 16;
      check(r <= exact && exact < r + 16, "R5 faithful", r, exact);
    end

    // R7: terms while idle are ignored.
    held = res_int();
    for (int k = 0; k < 3; k++) begin
      valid = 1'b1;
      tidx  = 2'(k);
      tvar  = 8'(50 + k);
      @(negedge clk);
      check(!done && res_int() == held, "R7 idle term", res_int(), held);
    end
    valid = 1'b0;

    // R8: restart part-way discards earlier terms.
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    valid = 1'b1; tidx = 2'd2; tvar = 8'd100;
    @(negedge clk);
    valid = 1'b1; tidx = 2'd2; tvar = 8'd99;
    @(negedge clk);
    valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ix = '{1, 3, 0, 2};
    vv = '{-5, 17, 64, -33};
    send_terms(ix, vv, early);
    check(!early && done && res_int() == expect_sum(ix, vv), "R8 restart",
          res_int(), expect_sum(ix, vv));
    @(negedge clk);

    // R2: a term presented together with start is dropped.
    start = 1'b1;
    valid = 1'b1; tidx = 2'd2; tvar = 8'd120;
    @(negedge clk);
    start = 1'b0;
    ix = '{0, 0, 1, 3};
    vv = '{11, -22, 33, -44};
    send_terms(ix, vv, early);
    check(!early && done && res_int() == expect_sum(ix, vv), "R2 start drops term",
          res_int(), expect_sum(ix, vv));
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule